// File: doc/BRIEF.md
# Fail-Safe Response Watchdog with Interrupt Control

This block guards a local device against a missing response. Every access to the device region starts a loadable countdown and marks a response as outstanding. If the count reaches zero before the device acknowledges, the block records a fail-safe error. It also raises an interrupt when that interrupt is enabled. The block holds the software-visible registers for this function: a global status word, an operation/interrupt control word, the running count, the preload value and a command word.

Access is a single-cycle register port. Every request is accepted on the cycle it is presented, so there is no back-pressure. One response comes back on the next cycle. The error and the interrupt can be cleared in two ways. If auto-clear is selected, a read of the upper half of the status word clears them. Otherwise software writes the clear bit of the command word. Word offsets 0x800 to 0x81C hold the registers. The device region is 0x000 to 0x0FC. Every other offset in the 4 KiB window is refused with an abort.

Top module: `fs_watchdog`

## Requirements
- R1: After reset, the registers read as follows: status 0x0100_0000 (bit 24 is a constant 1), control 0x0002_0000 (mode field bits 17:16 = 2'b10, halt), count 0, preload PRE_RST. `irq` is low.
- R2: Each accepted access (`acc_en` high at a clock edge) produces `rsp_valid` for exactly the next cycle. Read data shows register state from before that access took effect.
- R3: An access to offsets 0x100–0x7FC or 0x820–0xFFC returns `rsp_abort`=1 with data 0. It changes no register and raises no device request.
- R4: An access to offsets 0x000–0x0FC pulses `dev_req` in the next cycle. It loads the count from the preload value and marks a response as outstanding.
- R5: While a response is outstanding and the count is nonzero, the count (readable at 0x808) falls by one each cycle. `dev_ack` reloads the count from the preload value and ends the outstanding state.
- R6: If a response is outstanding, the count is 0 and no `dev_ack` arrives, the outstanding state ends. The error bit (status bit 22) is set only when the mode field (control bits 17:16) is not 2'b00.
- R7: A fault sets the interrupt only when control bit 19 is 1. Status bit 31 and the `irq` pin both show the interrupt.
- R8: When control bit 18 (auto-clear) is 1, a status read with `acc_lanes[1]`=1 clears the error and the interrupt. A read with only `acc_lanes[0]` does not.
- R9: When auto-clear is 0, status reads do not clear anything. A write to 0x81C with lane 0 and data bit 1 set clears the error and the interrupt.
- R10: A fault in the same cycle as either clear leaves the error set.
- R11: Writes obey lane enables (`acc_lanes[0]` = bits 15:0, `acc_lanes[1]` = bits 31:16). Control stores only bits 19:16 and preload only its low TMR_W bits. Writes to status and count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request, always accepted |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset in the 4 KiB window |
| acc_lanes | input | 2 | Half-word enables: bit 0 low half, bit 1 high half |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data |
| rsp_abort | output | 1 | Access refused (reserved offset) |
| dev_req | output | 1 | Pulse: a device access was issued |
| dev_ack | input | 1 | Device response |
| irq | output | 1 | Fail-safe interrupt |

## Verification
The response, the `dev_req` pulse and all register effects appear one cycle after the edge that accepts an access. A fault is recorded one cycle after the edge where the count is already 0, which makes the error visible P+1 edges after a device access with preload P. The bench carries a behavioural reference model that is advanced on the same rising edge as the design. It compares every output at the falling edge that follows. Directed reads sample the response at the falling edge after the accepting edge, and they check exact words taken from the requirements.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = 16;
  localparam int LANES    = DATA_W / HALF_W;
  localparam int CTRL_LSB = 16;
  localparam int CTRL_W   = 4;
  localparam int BIT_IRQ  = 31;
  localparam int BIT_ONE  = 24;
  localparam int BIT_ERR  = 22;
  localparam int CMD_CLR  = 1;
  localparam int C_IRQEN  = 3;
  localparam int C_AUTO   = 2;

  localparam logic [9:0] W_DEV_END = 10'h040;
  localparam logic [9:0] W_STAT    = 10'h200;
  localparam logic [9:0] W_CTRL    = 10'h201;
  localparam logic [9:0] W_TMR     = 10'h202;
  localparam logic [9:0] W_PRE     = 10'h203;
  localparam logic [9:0] W_CMD     = 10'h207;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_A    = 2'b01,
    MODE_HALT = 2'b10,
    MODE_B    = 2'b11
  } fs_mode_e;

  typedef enum logic [2:0] {
    SEL_DEV, SEL_RSVD, SEL_STAT, SEL_CTRL,
    SEL_TMR, SEL_PRE, SEL_SPARE, SEL_CMD
  } fs_sel_e;
endpackage

// File: rtl/fs_decode.sv
module fs_decode
  import fs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output fs_sel_e           sel
);
  logic [9:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    if (word < W_DEV_END) begin
      sel = SEL_DEV;
    end else if (word < W_STAT || word > W_CMD) begin
      sel = SEL_RSVD;
    end else begin
      case (word)
        W_STAT:  sel = SEL_STAT;
        W_CTRL:  sel = SEL_CTRL;
        W_TMR:   sel = SEL_TMR;
        W_PRE:   sel = SEL_PRE;
        W_CMD:   sel = SEL_CMD;
        default: sel = SEL_SPARE;
      endcase
    end
  end
endmodule

// File: rtl/fs_timer.sv
module fs_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ack,
  input  logic [TMR_W-1:0] preload,
  input  logic             mode_on,
  output logic [TMR_W-1:0] cnt,
  output logic             pend,
  output logic             fault
);
  logic expire;
  assign expire = pend && (cnt == '0) && !ack && !start;
  assign fault  = expire && mode_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (start) begin
      cnt  <= preload;
      pend <= 1'b1;
    end else if (pend && ack) begin
      cnt  <= preload;
      pend <= 1'b0;
    end else if (expire) begin
      pend <= 1'b0;
    end else if (pend) begin
      cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fs_regs.sv
module fs_regs
  import fs_pkg::*;
#(
  parameter int TMR_W   = 16,
  parameter int PRE_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [LANES-1:0]  acc_lanes,
  input  logic [DATA_W-1:0] acc_wdata,
  input  fs_sel_e           sel,
  input  logic              fault,
  input  logic [TMR_W-1:0]  cnt,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [TMR_W-1:0]  pre_q,
  output logic              err_q,
  output logic              irq_q,
  output logic              dev_start,
  output logic              mode_on,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_abort,
  output logic              dev_req
);
  localparam logic [CTRL_W-1:0] CTRL_RST = {2'b00, MODE_HALT};
  localparam logic [TMR_W-1:0]  PRE_INIT = TMR_W'(PRE_RST);

  logic [DATA_W-1:0] wmask;
  logic              wr_ctrl, wr_pre, clr_auto, clr_cmd, clr;
  logic [DATA_W-1:0] rd_word;

  for (genvar h = 0; h < LANES; h++) begin : g_lane
    assign wmask[h*HALF_W +: HALF_W] = {HALF_W{acc_lanes[h]}};
  end

  assign dev_start = acc_en && (sel == SEL_DEV);
  assign wr_ctrl   = acc_en && acc_wr && (sel == SEL_CTRL);
  assign wr_pre    = acc_en && acc_wr && (sel == SEL_PRE);
  assign clr_auto  = acc_en && !acc_wr && (sel == SEL_STAT) && acc_lanes[1] && ctrl_q[C_AUTO];
  assign clr_cmd   = acc_en && acc_wr && (sel == SEL_CMD) && acc_lanes[0] && acc_wdata[CMD_CLR];
  assign clr       = clr_auto || clr_cmd;
  assign mode_on   = fs_mode_e'(ctrl_q[1:0]) != MODE_OFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      pre_q  <= PRE_INIT;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= (ctrl_q & ~wmask[CTRL_LSB +: CTRL_W]) |
                  (acc_wdata[CTRL_LSB +: CTRL_W] & wmask[CTRL_LSB +: CTRL_W]);
      end
      if (wr_pre) begin
        pre_q <= (pre_q & ~wmask[TMR_W-1:0]) | (acc_wdata[TMR_W-1:0] & wmask[TMR_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (fault)    err_q <= 1'b1;
      else if (clr) err_q <= 1'b0;
      if (fault && ctrl_q[C_IRQEN]) irq_q <= 1'b1;
      else if (clr)                 irq_q <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_STAT: begin
        rd_word[BIT_IRQ] = irq_q;
        rd_word[BIT_ONE] = 1'b1;
        rd_word[BIT_ERR] = err_q;
      end
      SEL_CTRL: rd_word[CTRL_LSB +: CTRL_W] = ctrl_q;
      SEL_TMR:  rd_word[TMR_W-1:0] = cnt;
      SEL_PRE:  rd_word[TMR_W-1:0] = pre_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_abort <= 1'b0;
      dev_req   <= 1'b0;
    end else begin
      rsp_valid <= acc_en;
      rsp_abort <= acc_en && (sel == SEL_RSVD);
      rsp_rdata <= (acc_en && !acc_wr) ? rd_word : '0;
      dev_req   <= dev_start;
    end
  end
endmodule

// File: rtl/fs_watchdog.sv
module fs_watchdog
  import fs_pkg::*;
#(
  parameter int TMR_W   = 16,
  parameter int PRE_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LANES-1:0]  acc_lanes,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_abort,
  output logic              dev_req,
  input  logic              dev_ack,
  output logic              irq
);
  fs_sel_e           sel_w;
  logic [CTRL_W-1:0] ctrl_q;
  logic [TMR_W-1:0]  pre_q, cnt_q;
  logic              err_q, pend_q, fault_w, start_w, mode_on_w;

  fs_decode u_dec (.addr(acc_addr), .sel(sel_w));

  fs_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_w), .ack(dev_ack),
    .preload(pre_q), .mode_on(mode_on_w),
    .cnt(cnt_q), .pend(pend_q), .fault(fault_w)
  );

  fs_regs #(.TMR_W(TMR_W), .PRE_RST(PRE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_lanes(acc_lanes), .acc_wdata(acc_wdata), .sel(sel_w),
    .fault(fault_w), .cnt(cnt_q), .ctrl_q(ctrl_q), .pre_q(pre_q),
    .err_q(err_q), .irq_q(irq), .dev_start(start_w), .mode_on(mode_on_w),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort),
    .dev_req(dev_req)
  );
endmodule

// File: rtl/fs_watchdog_chk.sv
module fs_watchdog_chk #(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [11:0]      acc_addr,
  input logic [1:0]       acc_lanes,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_abort,
  input logic             dev_req,
  input logic             dev_ack,
  input logic             irq,
  input logic [3:0]       ctrl_q,
  input logic             err_q,
  input logic             fault_w,
  input logic             start_w,
  input logic             pend_q,
  input logic [TMR_W-1:0] cnt_q
);
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> rsp_valid); // R2

  AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |-> (rsp_valid && rsp_rdata == 32'h0 && !dev_req)); // R3

  AST_DEV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_addr < 12'h100) |=> dev_req); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q != '0 && !dev_ack && !start_w) |=> (cnt_q == $past(cnt_q) - TMR_W'(1))); // R5

  AST_ERR_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q == '0 && !dev_ack && !start_w && ctrl_q[1:0] == 2'b00 && !err_q) |=> !err_q); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ctrl_q[3]) |=> !irq); // R7

  AST_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr[11:2] == 10'h200 && acc_lanes[1] && ctrl_q[2] && !fault_w)
      |=> (!err_q && !irq)); // R8

  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_w |=> err_q); // R10
endmodule

bind fs_watchdog fs_watchdog_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .acc_lanes(acc_lanes), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort), .dev_req(dev_req),
  .dev_ack(dev_ack), .irq(irq), .ctrl_q(ctrl_q), .err_q(err_q),
  .fault_w(fault_w), .start_w(start_w), .pend_q(pend_q), .cnt_q(cnt_q)
);

// File: tb/sim_fs_watchdog.sv
module sim_fs_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_RST    = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  lanes = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid, rsp_abort, dev_req, irq;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference model state
  int m_ctrl, m_pre, m_cnt, m_pend, m_err, m_irq;
  int e_valid, e_rdata, e_abort, e_dreq;

  always #(CLK_PERIOD/2) clk = ~clk;

  fs_watchdog #(.TMR_W(16), .PRE_RST(PRE_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(en), .acc_wr(wr), .acc_addr(addr),
    .acc_lanes(lanes), .acc_wdata(wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort), .dev_req(dev_req),
    .dev_ack(ack), .irq(irq)
  );

  function automatic int region(input int a);
    int w = a >> 2;
    if (w < 'h40) return 0;                 // device
    if (w < 'h200 || w > 'h207) return 1;   // reserved
    return 2;
  endfunction

  function automatic int model_read(input int a);
    int w = a >> 2;
    if (region(a) != 2) return 0;
    case (w)
      'h200: return (m_irq << 31) | (1 << 24) | (m_err << 22);
      'h201: return m_ctrl << 16;
      'h202: return m_cnt;
      'h203: return m_pre;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 2; m_pre = PRE_RST; m_cnt = 0; m_pend = 0; m_err = 0; m_irq = 0;
      e_valid = 0; e_rdata = 0; e_abort = 0; e_dreq = 0;
    end else begin
      int a, rg, fault, clr, nctrl, npre, m;
      a = int'(addr); rg = region(a);
      e_valid = en; e_abort = en && rg == 1; e_dreq = en && rg == 0;
      e_rdata = (en && !wr) ? model_read(a) : 0;
      fault = 0;
      if (en && rg == 0) begin m_cnt = m_pre; m_pend = 1; end
      else if (m_pend && ack) begin m_cnt = m_pre; m_pend = 0; end
      else if (m_pend && m_cnt == 0) begin m_pend = 0; fault = ((m_ctrl & 3) != 0); end
      else if (m_pend) m_cnt = m_cnt - 1;
      clr = (en && !wr && (a >> 2) == 'h200 && lanes[1] && ((m_ctrl >> 2) & 1)) ||
            (en && wr && (a >> 2) == 'h207 && lanes[0] && wdata[1]);
      if (fault) m_err = 1; else if (clr) m_err = 0;
      if (fault && ((m_ctrl >> 3) & 1)) m_irq = 1; else if (clr) m_irq = 0;
      nctrl = m_ctrl; npre = m_pre;
      if (en && wr && (a >> 2) == 'h201 && lanes[1]) nctrl = (wdata >> 16) & 'hF;
      if (en && wr && (a >> 2) == 'h203 && lanes[0]) npre = wdata & 'hFFFF;
      m_ctrl = nctrl; m_pre = npre;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2: every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      chk("R2 rsp_rdata", rsp_rdata, 32'(e_rdata));
      chk("R3 rsp_abort", 32'(rsp_abort), 32'(e_abort));
      chk("R4 dev_req", 32'(dev_req), 32'(e_dreq));
      chk("R7 irq", 32'(irq), 32'(m_irq));
    end
  end

  // called at a falling edge; returns at the falling edge where the response is valid
  task automatic acc(input logic w, input logic [11:0] a, input logic [1:0] l,
                     input logic [31:0] d, output logic [31:0] rd);
    en = 1'b1; wr = w; addr = a; lanes = l; wdata = d;
    @(negedge clk);
    rd = rsp_rdata;
    en = 1'b0; wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    acc(0, 12'h800, 2'b11, 0, r); chk("R1 status", r, 32'h0100_0000);
    acc(0, 12'h804, 2'b11, 0, r); chk("R1 ctrl", r, 32'h0002_0000);
    acc(0, 12'h80C, 2'b11, 0, r); chk("R1 preload", r, 32'(PRE_RST));
    acc(0, 12'h808, 2'b11, 0, r); chk("R1 count", r, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    // R11 lane masking and field widths
    acc(1, 12'h804, 2'b01, 32'hFFFF_FFFF, r);
    acc(0, 12'h804, 2'b11, 0, r); chk("R11 ctrl low lane", r, 32'h0002_0000);
    acc(1, 12'h804, 2'b11, 32'hFFFF_FFFF, r);
    acc(0, 12'h804, 2'b11, 0, r); chk("R11 ctrl field", r, 32'h000F_0000);
    acc(1, 12'h804, 2'b11, 32'h0002_0000, r);
    acc(1, 12'h808, 2'b11, 32'h1234, r);
    acc(0, 12'h808, 2'b11, 0, r); chk("R11 count ro", r, 32'h0);
    acc(1, 12'h800, 2'b11, 32'hFFFF_FFFF, r);
    acc(0, 12'h800, 2'b11, 0, r); chk("R11 status ro", r, 32'h0100_0000);
    acc(1, 12'h80C, 2'b11, 32'hABCD_0005, r);
    acc(0, 12'h80C, 2'b11, 0, r); chk("R11 preload", r, 32'h5);
    // R4 / R5 countdown and acknowledge
    acc(0, 12'h010, 2'b11, 0, r); chk("R4 dev_req", 32'(dev_req), 32'h1);
    acc(0, 12'h808, 2'b11, 0, r); chk("R5 count load", r, 32'h5);
    acc(0, 12'h808, 2'b11, 0, r); chk("R5 count step", r, 32'h4);
    ack = 1'b1; idle(1); ack = 1'b0;
    acc(0, 12'h808, 2'b11, 0, r); chk("R5 ack reload", r, 32'h5);
    idle(10);
    acc(0, 12'h800, 2'b11, 0, r); chk("R5 no fault after ack", r, 32'h0100_0000);
    // R6 expiry, irq disabled (R7)
    acc(1, 12'h020, 2'b11, 0, r);
    idle(10);
    acc(0, 12'h800, 2'b11, 0, r); chk("R6 error set", r, 32'h0140_0000);
    chk("R7 irq off", 32'(irq), 32'h0);
    // R9 no auto-clear; command clear
    acc(0, 12'h800, 2'b11, 0, r); chk("R9 read no clear", r, 32'h0140_0000);
    acc(1, 12'h81C, 2'b01, 32'h2, r);
    acc(0, 12'h800, 2'b11, 0, r); chk("R9 cmd clear", r, 32'h0100_0000);
    // R8 / R7 auto-clear with interrupt
    acc(1, 12'h804, 2'b10, 32'h000E_0000, r);
    acc(0, 12'h000, 2'b11, 0, r);
    idle(10);
    chk("R7 irq raised", 32'(irq), 32'h1);
    acc(0, 12'h800, 2'b01, 0, r); chk("R8 low read keeps", r, 32'h8140_0000);
    acc(0, 12'h800, 2'b10, 0, r); chk("R8 high read value", r, 32'h8140_0000);
    acc(0, 12'h800, 2'b11, 0, r); chk("R8 cleared", r, 32'h0100_0000);
    chk("R8 irq low", 32'(irq), 32'h0);
    // R6 mode off: no error
    acc(1, 12'h804, 2'b10, 32'h000C_0000, r);
    acc(0, 12'h0FC, 2'b11, 0, r);
    idle(10);
    acc(0, 12'h800, 2'b11, 0, r); chk("R6 mode off", r, 32'h0100_0000);
    acc(0, 12'h808, 2'b11, 0, r); chk("R6 count at zero", r, 32'h0);
    // R10 fault and clear in the same cycle
    acc(1, 12'h804, 2'b10, 32'h0002_0000, r);
    acc(1, 12'h80C, 2'b01, 32'h0, r);
    acc(0, 12'h004, 2'b11, 0, r);
    acc(1, 12'h81C, 2'b01, 32'h2, r);
    acc(0, 12'h800, 2'b11, 0, r); chk("R10 fault wins", r, 32'h0140_0000);
    acc(1, 12'h81C, 2'b01, 32'h2, r);
    // R3 reserved offsets
    acc(0, 12'h100, 2'b11, 0, r); chk("R3 abort 100", 32'(rsp_abort), 32'h1);
    chk("R3 data 100", r, 32'h0);
    acc(0, 12'h7FC, 2'b11, 0, r); chk("R3 abort 7FC", 32'(rsp_abort), 32'h1);
    acc(0, 12'h820, 2'b11, 0, r); chk("R3 abort 820", 32'(rsp_abort), 32'h1);
    acc(1, 12'hFFC, 2'b11, 32'hFFFF_FFFF, r); chk("R3 abort FFC", 32'(rsp_abort), 32'h1);
    chk("R3 no dev_req", 32'(dev_req), 32'h0);
    acc(0, 12'h810, 2'b11, 0, r); chk("R3 spare no abort", 32'(rsp_abort), 32'h0);
    acc(0, 12'h804, 2'b11, 0, r); chk("R3 ctrl untouched", r, 32'h0002_0000);
    acc(0, 12'h80C, 2'b11, 0, r); chk("R3 preload untouched", r, 32'h0);
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule